// File: doc/BRIEF.md
# Multi-link sync point controller

This block sets the common timing of a bus controller that drives several audio links. A free-running counter on the oscillator clock produces a one-cycle synchronization pulse. Software programs the period to suit the oscillator: a count of 5999 gives 4 kHz from 24 MHz, and 9599 gives 4 kHz from 38.4 MHz. The same control word holds three further parts. A CPU-sync bit tells software when the first link has come up. Each link has an arm bit. A go bit makes every armed link switch banks in the same sync slot.

Each link also has a power request bit. Its acknowledge follows the request after a fixed number of cycles, so software can poll for it. Each link also has a wake enable bit and a wake status bit. The wake status bit latches wake events and is cleared by writing 1 to it. A plain read/write register port reaches all state. The block drives the sync pulse, one bank-switch strobe per link and one power request per link.

Top module: `sync_point_ctrl`

## Requirements
- R1: After reset, word 0 reads the period reset value (5999) and all its other fields read 0. Words 1 and 2 read 0, and all outputs are low.
- R2: `sync_pulse_o` is one cycle wide and repeats every period+1 cycles. The period is bits [15:0] of word 0 (address 0).
- R3: A write to word 0 sets the arm bit of each link whose data bit in [23:20] (link 0 at bit 20) is 1. A 0 in that field leaves the arm bit unchanged.
- R4: Writing 1 to bit 31 of word 0 (go) raises `bank_switch_o` equal to the armed set. The strobe lasts one cycle, comes at the first sync pulse after the write, and coincides with it.
- R5: In that same slot, go and every arm bit clear. If go is written with no link armed, no strobe appears and go still clears at the next sync pulse.
- R6: Writing 1 to bit 16 of word 0 sets CPU-sync. The bit stays set while no power acknowledge is high. It clears at the first sync pulse that sees at least one acknowledge high.
- R7: Word 1 (address 1) holds the power requests in [3:0], which also drive `link_pwr_req_o`. The read-only acknowledges are in [11:8]. Each acknowledge takes the new value of its request exactly PWR_LAT cycles after the request changes, on both the rising and the falling transition.
- R8: Word 2 (address 2) holds the wake enables in [3:0] and the wake status in [11:8]. A high `link_wake_i` bit sets its status bit only when that link is enabled. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R9: A new period value takes effect on the following intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 2 | Word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| link_wake_i | input | NUM_LINKS | Wake event from each link |
| sync_pulse_o | output | 1 | One-cycle synchronization pulse |
| bank_switch_o | output | NUM_LINKS | Bank-switch strobe for each link |
| link_pwr_req_o | output | NUM_LINKS | Power request to each link |

## Verification
The assertions take for granted two things about software. First, a nonzero period is kept while go is pending. Second, software does not arm a link in the very cycle the armed set fires, since in that cycle the clear wins over the new arm bit. The stimulus keeps to both rules. Every random period lies between 2 and 30. Each go is written after its arm write, and then only while waiting for the slot. Wake events are driven only at instants when no write to word 2 is in progress.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_POWER = 2'd1,
        ADDR_WAKE  = 2'd2,
        ADDR_RSVD  = 2'd3
    } spc_addr_e;

    // bit positions inside the control word
    localparam int CPUSYNC_BIT = 16;
    localparam int ARM_LSB     = 20;
    localparam int GO_BIT      = 31;
    // upper field of the power and wake words
    localparam int HI_LSB      = 8;

endpackage

// File: rtl/spc_tick_gen.sv
module spc_tick_gen #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [PERIOD_W-1:0] period_i,
    output logic                tick_o
);

    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        tick_o = (st_q.cnt >= period_i);
        if (tick_o) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R2: with a nonzero period a pulse never lasts two cycles
    assert_pulse_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && period_i != '0) |=> (!tick_o || period_i == '0));

    // R2: the count restarts from zero after every pulse
    assert_count_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (st_q.cnt == '0));

endmodule

// File: rtl/spc_link_power.sv
module spc_link_power #(
    parameter int LAT = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic ack_o
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ack;
    } pwr_st_t;

    pwr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i != st_q.ack) begin
            if (st_q.cnt == LAST) begin
                st_d.ack = req_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ack_o = st_q.ack;

    // R7: the acknowledge only ever moves toward the request
    assert_ack_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(ack_o) |-> (ack_o == $past(req_i)));

    // R7: a settled acknowledge holds while the request agrees with it
    assert_ack_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i == ack_o) |=> $stable(ack_o));

endmodule

// File: rtl/sync_point_ctrl.sv
module sync_point_ctrl #(
    parameter int NUM_LINKS    = 4,
    parameter int PERIOD_W     = 16,
    parameter int PERIOD_RESET = 5999,
    parameter int PWR_LAT      = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_we_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic [NUM_LINKS-1:0] link_wake_i,
    output logic                 sync_pulse_o,
    output logic [NUM_LINKS-1:0] bank_switch_o,
    output logic [NUM_LINKS-1:0] link_pwr_req_o
);
    import spc_pkg::*;

    localparam logic [PERIOD_W-1:0] PERIOD_INIT = PERIOD_W'(PERIOD_RESET);

    typedef struct packed {
        logic [PERIOD_W-1:0]  period;
        logic                 cpu_sync;
        logic [NUM_LINKS-1:0] arm;
        logic                 go;
        logic [NUM_LINKS-1:0] pwr_req;
        logic [NUM_LINKS-1:0] wake_en;
        logic [NUM_LINKS-1:0] wake_sts;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic                 tick;
    logic                 fire;
    logic [NUM_LINKS-1:0] pwr_ack;
    logic                 wr_ctrl, wr_power, wr_wake;

    spc_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .period_i (st_q.period),
        .tick_o   (tick)
    );

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        spc_link_power #(.LAT(PWR_LAT)) u_pwr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (st_q.pwr_req[g]),
            .ack_o  (pwr_ack[g])
        );
    end

    always_comb begin
        wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
        wr_power = reg_we_i && (reg_addr_i == ADDR_POWER);
        wr_wake  = reg_we_i && (reg_addr_i == ADDR_WAKE);
        fire     = tick && st_q.go;

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.period = reg_wdata_i[PERIOD_W-1:0];
            st_d.arm    = st_q.arm | reg_wdata_i[ARM_LSB +: NUM_LINKS];
            if (reg_wdata_i[GO_BIT])      st_d.go       = 1'b1;
            if (reg_wdata_i[CPUSYNC_BIT]) st_d.cpu_sync = 1'b1;
        end
        if (fire) begin
            st_d.arm = '0;
            st_d.go  = 1'b0;
        end
        if (tick && (|pwr_ack)) st_d.cpu_sync = 1'b0;

        if (wr_power) st_d.pwr_req = reg_wdata_i[NUM_LINKS-1:0];

        if (wr_wake) begin
            st_d.wake_en  = reg_wdata_i[NUM_LINKS-1:0];
            st_d.wake_sts = st_q.wake_sts & ~reg_wdata_i[HI_LSB +: NUM_LINKS];
        end
        st_d.wake_sts = st_d.wake_sts | (link_wake_i & st_q.wake_en);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q        <= '0;
            st_q.period <= PERIOD_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[PERIOD_W-1:0]           = st_q.period;
                reg_rdata_o[CPUSYNC_BIT]            = st_q.cpu_sync;
                reg_rdata_o[ARM_LSB +: NUM_LINKS]   = st_q.arm;
                reg_rdata_o[GO_BIT]                 = st_q.go;
            end
            ADDR_POWER: begin
                reg_rdata_o[NUM_LINKS-1:0]          = st_q.pwr_req;
                reg_rdata_o[HI_LSB +: NUM_LINKS]    = pwr_ack;
            end
            ADDR_WAKE: begin
                reg_rdata_o[NUM_LINKS-1:0]          = st_q.wake_en;
                reg_rdata_o[HI_LSB +: NUM_LINKS]    = st_q.wake_sts;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    assign sync_pulse_o   = tick;
    assign bank_switch_o  = fire ? st_q.arm : '0;
    assign link_pwr_req_o = st_q.pwr_req;

    // R4: a pending go survives until a sync pulse arrives
    assert_go_waits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.go && !sync_pulse_o) |=> st_q.go);

    // R4: a bank-switch strobe lasts a single cycle
    assert_strobe_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bank_switch_o != '0) |=> (bank_switch_o == '0));

    // R5: the slot that fires leaves nothing armed and go cleared
    assert_fire_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_pulse_o && st_q.go) |=> (st_q.arm == '0 && !st_q.go));

    // R6: CPU-sync drops on a pulse that sees an acknowledge
    assert_cpusync_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_pulse_o && (|pwr_ack)) |=> !st_q.cpu_sync);

    // R8: a status bit never appears for a link that was not enabled
    assert_wake_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((st_q.wake_sts & ~$past(st_q.wake_sts) & ~$past(st_q.wake_en)) == '0));

endmodule

// File: tb/sync_point_ctrl_tb.sv
module sync_point_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int LAT = 5;
    localparam int PRST = 5999;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [N-1:0] link_wake_i = '0;
    logic        sync_pulse_o;
    logic [N-1:0] bank_switch_o;
    logic [N-1:0] link_pwr_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    sync_point_ctrl #(.NUM_LINKS(N), .PERIOD_W(16), .PERIOD_RESET(PRST), .PWR_LAT(LAT)) u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .link_wake_i(link_wake_i),
        .sync_pulse_o(sync_pulse_o), .bank_switch_o(bank_switch_o),
        .link_pwr_req_o(link_pwr_req_o)
    );

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    function automatic logic [31:0] ctrl_word(int per, bit cpu, logic [N-1:0] arm, bit go);
        logic [31:0] w = '0;
        w[15:0]  = 16'(per);
        w[16]    = cpu;
        w[20 +: N] = arm;
        w[31]    = go;
        return w;
    endfunction

    function automatic logic [31:0] hi_lo(logic [N-1:0] hi, logic [N-1:0] lo);
        logic [31:0] w = '0;
        w[N-1:0] = lo;
        w[8 +: N] = hi;
        return w;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk_i);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(negedge clk_i);
    endtask

    task automatic wait_pulse();
        int guard = 0;
        while (!sync_pulse_o && guard < 100000) begin
            @(negedge clk_i);
            guard++;
        end
    endtask

    task automatic measure_gap(output int gap);
        wait_pulse();
        @(negedge clk_i);
        gap = 1;
        while (!sync_pulse_o && gap < 100000) begin
            @(negedge clk_i);
            gap++;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        int gap;
        int per;
        logic [N-1:0] mask;
        void'($urandom(32'd4242));

        step(3);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        rd(2'd0, r); check(r == ctrl_word(PRST, 0, '0, 0), "R1 ctrl", r, ctrl_word(PRST, 0, '0, 0));
        rd(2'd1, r); check(r == 32'd0, "R1 power", r, 32'd0);
        rd(2'd2, r); check(r == 32'd0, "R1 wake", r, 32'd0);
        check(bank_switch_o == '0 && link_pwr_req_o == '0, "R1 outputs",
              {bank_switch_o, link_pwr_req_o}, 32'd0);

        // R2, R9 period change and pulse spacing
        per = 9;
        wr(2'd0, ctrl_word(per, 0, '0, 0));
        measure_gap(gap);
        measure_gap(gap);
        check(gap == per + 1, "R9 new period", gap, per + 1);
        for (int k = 0; k < 5; k++) begin
            per = 2 + int'($urandom_range(28));
            wr(2'd0, ctrl_word(per, 0, '0, 0));
            measure_gap(gap);
            measure_gap(gap);
            check(gap == per + 1, "R2 pulse interval", gap, per + 1);
        end

        // R3 arm bits are set-only
        per = 7;
        wr(2'd0, ctrl_word(per, 0, 4'b0101, 0));
        rd(2'd0, r); check(r == ctrl_word(per, 0, 4'b0101, 0), "R3 arm set", r, ctrl_word(per, 0, 4'b0101, 0));
        wr(2'd0, ctrl_word(per, 0, 4'b0010, 0));
        rd(2'd0, r); check(r == ctrl_word(per, 0, 4'b0111, 0), "R3 arm accumulate", r, ctrl_word(per, 0, 4'b0111, 0));
        wr(2'd0, ctrl_word(per, 0, 4'b0000, 0));
        rd(2'd0, r); check(r == ctrl_word(per, 0, 4'b0111, 0), "R3 zero keeps arm", r, ctrl_word(per, 0, 4'b0111, 0));

        // R4, R5 directed go
        wr(2'd0, ctrl_word(per, 0, '0, 1));
        rd(2'd0, r); check(r[31] == 1'b1, "R4 go pending", r, ctrl_word(per, 0, 4'b0111, 1));
        while (!sync_pulse_o) begin
            check(bank_switch_o == '0, "R4 no early strobe", bank_switch_o, 0);
            @(negedge clk_i);
        end
        check(bank_switch_o == 4'b0111, "R4 strobe at pulse", bank_switch_o, 4'b0111);
        @(negedge clk_i);
        check(bank_switch_o == '0, "R4 strobe width", bank_switch_o, 0);
        rd(2'd0, r); check(r == ctrl_word(per, 0, '0, 0), "R5 cleared after fire", r, ctrl_word(per, 0, '0, 0));

        // R5 go with nothing armed
        wr(2'd0, ctrl_word(per, 0, '0, 1));
        wait_pulse();
        check(bank_switch_o == '0, "R5 no strobe unarmed", bank_switch_o, 0);
        @(negedge clk_i);
        rd(2'd0, r); check(r[31] == 1'b0, "R5 go self-clears", r, ctrl_word(per, 0, '0, 0));

        // R4 random armed sets and periods
        for (int k = 0; k < 20; k++) begin
            per  = 2 + int'($urandom_range(13));
            mask = N'($urandom_range(15));
            wr(2'd0, ctrl_word(per, 0, mask, 0));
            wr(2'd0, ctrl_word(per, 0, '0, 1));
            wait_pulse();
            check(bank_switch_o == mask, "R4 random strobe", bank_switch_o, mask);
            @(negedge clk_i);
            rd(2'd0, r); check(r == ctrl_word(per, 0, '0, 0), "R5 random clear", r, ctrl_word(per, 0, '0, 0));
        end

        // R6 CPU-sync waits for an acknowledge
        per = 6;
        wr(2'd0, ctrl_word(per, 1, '0, 0));
        wait_pulse(); @(negedge clk_i); wait_pulse(); @(negedge clk_i);
        rd(2'd0, r); check(r[16] == 1'b1, "R6 held without ack", r, ctrl_word(per, 1, '0, 0));

        // R7 power up latency
        wr(2'd1, 32'h1);
        check(link_pwr_req_o == 4'b0001, "R7 request out", link_pwr_req_o, 4'b0001);
        step(LAT - 1);
        rd(2'd1, r); check(r == hi_lo(4'b0000, 4'b0001), "R7 ack not yet", r, hi_lo(4'b0000, 4'b0001));
        step(1);
        rd(2'd1, r); check(r == hi_lo(4'b0001, 4'b0001), "R7 ack rises", r, hi_lo(4'b0001, 4'b0001));

        wait_pulse(); @(negedge clk_i);
        rd(2'd0, r); check(r[16] == 1'b0, "R6 cleared at pulse", r, ctrl_word(per, 0, '0, 0));

        // R7 power down latency
        wr(2'd1, 32'h0);
        step(LAT - 1);
        rd(2'd1, r); check(r == hi_lo(4'b0001, 4'b0000), "R7 ack still high", r, hi_lo(4'b0001, 4'b0000));
        step(1);
        rd(2'd1, r); check(r == 32'd0, "R7 ack falls", r, 32'd0);

        for (int k = 0; k < 4; k++) begin
            mask = N'($urandom_range(15));
            wr(2'd1, {28'd0, mask});
            step(LAT);
            rd(2'd1, r); check(r == hi_lo(mask, mask), "R7 random", r, hi_lo(mask, mask));
        end

        // R8 wake enables and write-1-to-clear
        wr(2'd2, 32'h0);
        link_wake_i = 4'b1111; @(negedge clk_i); link_wake_i = '0;
        rd(2'd2, r); check(r == 32'd0, "R8 disabled ignored", r, 32'd0);
        wr(2'd2, 32'hF);
        link_wake_i = 4'b0110; @(negedge clk_i); link_wake_i = '0;
        rd(2'd2, r); check(r == hi_lo(4'b0110, 4'b1111), "R8 status set", r, hi_lo(4'b0110, 4'b1111));
        wr(2'd2, hi_lo(4'b0000, 4'b1111));
        rd(2'd2, r); check(r == hi_lo(4'b0110, 4'b1111), "R8 zero keeps", r, hi_lo(4'b0110, 4'b1111));
        wr(2'd2, hi_lo(4'b0010, 4'b1111));
        rd(2'd2, r); check(r == hi_lo(4'b0100, 4'b1111), "R8 clear one", r, hi_lo(4'b0100, 4'b1111));
        wr(2'd2, hi_lo(4'b0100, 4'b0011));
        link_wake_i = 4'b1100; @(negedge clk_i); link_wake_i = '0;
        rd(2'd2, r); check(r == hi_lo(4'b0000, 4'b0011), "R8 clear and gate", r, hi_lo(4'b0000, 4'b0011));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule